// File: doc/BRIEF.md
# Register Window Pointer Unit

This block keeps the current window pointer and the saved window pointer of a processor whose register file is split into overlapping windows. It turns the 5-bit architectural register numbers of an instruction into physical register-file indices, so that the register file itself only sees flat indices. A call-type strobe moves to the next lower window and a return-type strobe (qualified by its branch condition) moves back up. Both pointers wrap modulo the window count.

The architectural space has four groups. Numbers 0 to 9 are globals that map to physical 0 to 9 whatever the window. Numbers 10 to 15 are incoming arguments, 16 to 25 are locals and 26 to 31 are outgoing arguments. Window w owns a 16-entry frame at physical base 10 + 16*w: incoming registers take offsets 0 to 5 and locals take offsets 6 to 15. Outgoing registers of window w are the incoming registers of window w-1 (mod 8). So a caller's outgoing arguments are seen by the callee as its incoming arguments.

A call that would land on the saved window does not move the pointer. Instead it raises a one-cycle overflow trap carrying a fixed vector. A taken return that would land on the saved window raises a one-cycle underflow trap on its own vector output, and the pointer stays where it was. Source indices always use the window in force before the operation. The destination index of a call uses the window after the call.

Top module: `regwin_ptr`

## Requirements
- R1: After reset the current window is 0 and the saved window is 1. Both trap flags and the protocol error flag are low, and both vector outputs are 0.
- R2: A call (call_i high at a clock edge) whose decremented window differs from the saved window sets the current window to (cwp - 1) mod 8 at that edge.
- R3: A call whose decremented window equals the saved window leaves the current window unchanged. For exactly the next cycle it drives ovf_trap_o high and ovf_vec_o to 0x80000020; otherwise ovf_vec_o is 0.
- R4: A return (ret_i high, ret_cond_i high, call_i low) whose incremented window differs from the saved window sets the current window to (cwp + 1) mod 8.
- R5: A return with ret_cond_i low changes nothing and raises no trap.
- R6: A taken return whose incremented window equals the saved window leaves the current window unchanged. For exactly the next cycle it drives unf_trap_o high and unf_vec_o to 0x80000024; otherwise unf_vec_o is 0.
- R7: The rs1 and rs2 indices are combinational and always use the current (pre-operation) window. Register numbers 10 to 25 map to 10 + 16*cwp + (r - 10).
- R8: The rd index uses window (cwp - 1) mod 8 while call_i is high, and the current window otherwise.
- R9: Register numbers 0 to 9 map to the physical index equal to the number, for every window.
- R10: Register numbers 26 to 31 in window w map to 10 + 16*((w - 1) mod 8) + (r - 26), the incoming registers of the next lower window.
- R11: If call_i and ret_i are high together, only the call acts. proto_err_o then goes high at that edge and stays high until reset.
- R12: When swp_we_i is high, swp_wdata_i becomes the saved window at the edge. The comparison in the same cycle still uses the previous saved window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call-type operation strobe |
| ret_i | input | 1 | Return-type operation strobe |
| ret_cond_i | input | 1 | Branch condition of the return; the return acts only when high |
| swp_we_i | input | 1 | Saved window write enable |
| swp_wdata_i | input | 3 | New saved window value |
| rs1_i | input | 5 | First source architectural register |
| rs2_i | input | 5 | Second source architectural register |
| rd_i | input | 5 | Destination architectural register |
| cwp_o | output | 3 | Current window pointer |
| rs1_idx_o | output | 8 | Physical index of rs1 |
| rs2_idx_o | output | 8 | Physical index of rs2 |
| rd_idx_o | output | 8 | Physical index of rd |
| ovf_trap_o | output | 1 | Window overflow trap request |
| ovf_vec_o | output | 32 | Overflow trap vector, 0 when no trap |
| unf_trap_o | output | 1 | Window underflow trap request |
| unf_vec_o | output | 32 | Underflow trap vector, 0 when no trap |
| proto_err_o | output | 1 | Sticky flag for simultaneous call and return |

## Verification
The bench walks the pointer down from 0 through the wrap to 7 until the seventh call meets the saved window. A design with an off-by-one compare would trap a call early or let it overwrite the saved window. It returns right after reset to hit the underflow case, and issues a return with a false condition, which a design that ignores the condition would turn into a pointer move. It checks aliasing of outgoing and incoming registers across the window 0 to 7 wrap. A wrong modulo there would send arguments to the wrong frame. It also covers a saved-window write in the same cycle as a call, and simultaneous strobes, where a design giving return priority would move the pointer up.

// File: rtl/regwin_ptr.sv
module regwin_ptr #(
  parameter int NWIN  = 8,
  parameter int NGLOB = 10,
  parameter int NSHR  = 6,
  parameter int NLOC  = 10,
  parameter logic [31:0] OVF_VEC = 32'h8000_0020,
  parameter logic [31:0] UNF_VEC = 32'h8000_0024
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            call_i,
  input  logic                                            ret_i,
  input  logic                                            ret_cond_i,
  input  logic                                            swp_we_i,
  input  logic [$clog2(NWIN)-1:0]                         swp_wdata_i,
  input  logic [$clog2(NGLOB+2*NSHR+NLOC)-1:0]            rs1_i,
  input  logic [$clog2(NGLOB+2*NSHR+NLOC)-1:0]            rs2_i,
  input  logic [$clog2(NGLOB+2*NSHR+NLOC)-1:0]            rd_i,
  output logic [$clog2(NWIN)-1:0]                         cwp_o,
  output logic [$clog2(NGLOB+NWIN*(NSHR+NLOC))-1:0]       rs1_idx_o,
  output logic [$clog2(NGLOB+NWIN*(NSHR+NLOC))-1:0]       rs2_idx_o,
  output logic [$clog2(NGLOB+NWIN*(NSHR+NLOC))-1:0]       rd_idx_o,
  output logic                                            ovf_trap_o,
  output logic [31:0]                                     ovf_vec_o,
  output logic                                            unf_trap_o,
  output logic [31:0]                                     unf_vec_o,
  output logic                                            proto_err_o
);
  localparam int WB     = $clog2(NWIN);
  localparam int AW     = $clog2(NGLOB + 2*NSHR + NLOC);
  localparam int FRAME  = NSHR + NLOC;
  localparam int PW     = $clog2(NGLOB + NWIN*FRAME);
  localparam int OUT_LO = NGLOB + NSHR + NLOC;

  logic [WB-1:0] cwp_q, swp_q;
  logic          ovf_q, unf_q, perr_q;

  function automatic logic [WB-1:0] wprev(input logic [WB-1:0] w);
    return (w == '0) ? WB'(NWIN-1) : w - 1'b1;
  endfunction

  function automatic logic [WB-1:0] wnext(input logic [WB-1:0] w);
    return (int'(w) == NWIN-1) ? '0 : w + 1'b1;
  endfunction

  function automatic logic [PW-1:0] phys(input logic [WB-1:0] w, input logic [AW-1:0] r);
    if (int'(r) < NGLOB)       return PW'(int'(r));
    else if (int'(r) < OUT_LO) return PW'(NGLOB + int'(w)*FRAME + int'(r) - NGLOB);
    else                       return PW'(NGLOB + int'(wprev(w))*FRAME + int'(r) - OUT_LO);
  endfunction

  logic [WB-1:0] cwp_dn, cwp_up;
  logic          call_hit, ret_go, ret_hit;

  assign cwp_dn   = wprev(cwp_q);
  assign cwp_up   = wnext(cwp_q);
  assign call_hit = (cwp_dn == swp_q);
  assign ret_go   = ret_i && ret_cond_i && !call_i;
  assign ret_hit  = (cwp_up == swp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp_q  <= '0;
      swp_q  <= WB'(1);
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      ovf_q <= call_i && call_hit;
      unf_q <= ret_go && ret_hit;
      if (call_i && ret_i) perr_q <= 1'b1;
      if (call_i) begin
        if (!call_hit) cwp_q <= cwp_dn;
      end else if (ret_go && !ret_hit) begin
        cwp_q <= cwp_up;
      end
      if (swp_we_i) swp_q <= swp_wdata_i;
    end
  end

  assign cwp_o       = cwp_q;
  assign rs1_idx_o   = phys(cwp_q, rs1_i);
  assign rs2_idx_o   = phys(cwp_q, rs2_i);
  assign rd_idx_o    = phys(call_i ? cwp_dn : cwp_q, rd_i);
  assign ovf_trap_o  = ovf_q;
  assign unf_trap_o  = unf_q;
  assign ovf_vec_o   = ovf_q ? OVF_VEC : '0;
  assign unf_vec_o   = unf_q ? UNF_VEC : '0;
  assign proto_err_o = perr_q;

  p_call_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    call_i && (wprev(cwp_o) != swp_q) |=> cwp_o == wprev($past(cwp_o)));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    call_i && (wprev(cwp_o) == swp_q) |=> $stable(cwp_o) && ovf_trap_o);
  p_ret_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && ret_cond_i && !call_i && (wnext(cwp_o) != swp_q) |=> cwp_o == wnext($past(cwp_o)));
  p_ret_false_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && !ret_cond_i && !call_i |=> $stable(cwp_o) && !unf_trap_o && !ovf_trap_o);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && ret_cond_i && !call_i && (wnext(cwp_o) == swp_q) |=> $stable(cwp_o) && unf_trap_o);
  p_trap_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_trap_o, unf_trap_o}));
  p_alias_r8: assert property (@(posedge clk) disable iff (!rst_n)
    call_i && int'(rd_i) >= NGLOB && int'(rd_i) < NGLOB + NSHR
      && int'(rs1_i) == int'(rd_i) + OUT_LO - NGLOB |-> rd_idx_o == rs1_idx_o);
  p_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rs2_i) < NGLOB |-> int'(rs2_idx_o) == int'(rs2_i));
  p_perr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o);
endmodule

// File: tb/regwin_ptr_tb.sv
module regwin_ptr_tb;
  logic        clk = 0, rst_n = 0;
  logic        call_i = 0, ret_i = 0, ret_cond_i = 0, swp_we_i = 0;
  logic [2:0]  swp_wdata_i = 0;
  logic [4:0]  rs1_i = 0, rs2_i = 0, rd_i = 0;
  logic [2:0]  cwp_o;
  logic [7:0]  rs1_idx_o, rs2_idx_o, rd_idx_o;
  logic        ovf_trap_o, unf_trap_o, proto_err_o;
  logic [31:0] ovf_vec_o, unf_vec_o;

  regwin_ptr u_dut (.*);

  always #5 clk = ~clk;

  typedef struct packed {
    logic [2:0] cwp;
    logic       ovf, unf, perr;
  } exp_t;

  exp_t  q_exp[$];
  string q_tag[$];
  int    checks = 0, errors = 0;
  logic [2:0] m_cwp = 0, m_swp = 1;
  logic       m_perr = 0;

  function automatic int phys(input int w, input int r);
    if (r < 10)      return r;
    else if (r < 26) return 10 + 16*w + r - 10;
    else             return 10 + 16*((w + 7) % 8) + r - 26;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input string tag, input logic c, input logic r, input logic cond,
                    input logic we, input logic [2:0] wd,
                    input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
    exp_t e;
    logic [2:0] nw;
    @(negedge clk);
    call_i = c; ret_i = r; ret_cond_i = cond; swp_we_i = we; swp_wdata_i = wd;
    rs1_i = a; rs2_i = b; rd_i = d;
    #1;
    chk({tag, " R7 rs1"}, rs1_idx_o, phys(m_cwp, a));
    chk({tag, " R7 rs2"}, rs2_idx_o, phys(m_cwp, b));
    chk({tag, " R8 rd"},  rd_idx_o,  phys(c ? (m_cwp + 7) % 8 : m_cwp, d));
    e.ovf = 0; e.unf = 0;
    if (c) begin
      nw = m_cwp - 3'd1;
      if (nw == m_swp) e.ovf = 1; else m_cwp = nw;
    end else if (r && cond) begin
      nw = m_cwp + 3'd1;
      if (nw == m_swp) e.unf = 1; else m_cwp = nw;
    end
    if (c && r) m_perr = 1;
    if (we) m_swp = wd;
    e.cwp = m_cwp; e.perr = m_perr;
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && q_exp.size() > 0) begin
      exp_t  e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      chk({t, " cwp"},  cwp_o, e.cwp);
      chk({t, " R3 ovf"}, ovf_trap_o, e.ovf);
      chk({t, " R3 ovf_vec"}, ovf_vec_o, e.ovf ? 32'h8000_0020 : 32'h0);
      chk({t, " R6 unf"}, unf_trap_o, e.unf);
      chk({t, " R6 unf_vec"}, unf_vec_o, e.unf ? 32'h8000_0024 : 32'h0);
      chk({t, " R11 perr"}, proto_err_o, e.perr);
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 cwp", cwp_o, 0);
    chk("R1 ovf", ovf_trap_o, 0);
    chk("R1 unf", unf_trap_o, 0);
    chk("R1 perr", proto_err_o, 0);
    chk("R1 vecs", ovf_vec_o | unf_vec_o, 0);
    op("R6 R1 ret from reset", 0, 1, 1, 0, 0, 12, 3, 0);
    op("R5 ret cond false", 0, 1, 0, 0, 0, 20, 27, 0);
    op("idle", 0, 0, 0, 0, 0, 9, 31, 26);
    for (int i = 0; i < 6; i++)
      op("R2 R10 call down", 1, 0, 0, 0, 0, 5'(26 + i), 5'(16 + i), 5'(10 + i));
    op("R3 call onto swp", 1, 0, 0, 0, 0, 31, 0, 15);
    op("R3 trap clears", 0, 0, 0, 0, 0, 25, 26, 11);
    for (int i = 0; i < 3; i++)
      op("R4 ret up", 0, 1, 1, 0, 0, 5'(10 + i), 5'(28 + i), 5'(i));
    op("R12 swp write with call", 1, 0, 0, 1, 3'd3, 29, 4, 13);
    op("R12 call after swp write", 1, 0, 0, 0, 0, 30, 17, 12);
    op("R12 call onto new swp", 1, 0, 0, 0, 0, 26, 10, 10);
    op("R11 both strobes", 1, 1, 1, 0, 0, 27, 21, 14);
    op("R11 sticky", 0, 1, 1, 0, 0, 18, 7, 5);
    for (int i = 0; i < 6; i++)
      op("R9 R10 sweep", 0, 1, 1, 0, 0, 5'(i * 5), 5'(31 - i), 5'(26 + i));
    op("R6 ret onto swp", 0, 1, 1, 1, 3'(m_cwp + 3'd1), 1, 2, 3);
    op("R6 ret onto swp again", 0, 1, 1, 0, 0, 1, 2, 3);
    op("tail", 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #3;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule